// File: doc/BRIEF.md
# Halt-Mode Wake and Reset-Flag Controller

This controller sits next to a small processor core and governs the low-power halt state. When the core issues its halt instruction, the controller gates off the system clock. It sets the power-down status flag, clears the time-out flag and asks the watchdog to restart its count. RAM, registers and port levels are left alone.

While halted, the controller watches for several wake sources:
- falling edges on wake-enabled port bits;
- either edge on a remote-control pin;
- interrupt requests that were not already pending when the halt began;
- watchdog overflow;
- external reset.

When one of them fires, the controller restores the clock and picks a resume mode. A watchdog wake raises a warm reset, which clears only the program counter and stack pointer, and sets the time-out flag. An external reset raises a full chip reset. A fixed settle period then runs, after which a single-cycle resume strobe tells the core to continue.

The resume strobe carries one of two resume modes. In one, the core carries on at the next instruction. In the other, it takes the normal interrupt response. The interrupt response is used only when the waking interrupt is enabled and the stack has room.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sys_clk_en`=1, `pdf`=0, `to_flag`=0, and `chip_reset`, `warm_reset` and `resume_strobe` are 0. A reset taken while halted returns the block to the running state.
- R2: A `halt_strobe` in the running state, with no `ext_reset` in the same cycle, makes the next cycle show `sys_clk_en`=0, `pdf`=1, `to_flag`=0 and a one-cycle `wdt_restart`=1.
- R3: While halted, a 1-to-0 transition on `port_in[i]` with `port_wake_en[i]`=1 wakes the block with `resume_mode`=0 (next instruction). The following do not wake it:
  - a falling edge on a bit whose enable is 0;
  - a rising edge on any port bit;
  - an edge that happened while running.
- R4: While halted, either a rising or a falling edge on `rmt_in` wakes the block with `resume_mode`=0.
- R5: While halted, a bit of `irq_req` that is 1 and was 0 at halt entry wakes the block. `resume_mode` is 1 (interrupt vector) when such a bit also has its `irq_en` bit set and `stack_full`=0; otherwise it is 0.
- R6: An `irq_req` bit that was already 1 in the cycle of halt entry cannot wake the block during that halt.
- R7: `wdt_ovf` while halted gives `warm_reset`=1 for exactly the cycle after the wake, sets `to_flag`=1, keeps `pdf`=1 and selects `resume_mode`=0.
- R8: `ext_reset` gives `chip_reset`=1 for the following cycle and leaves `pdf` and `to_flag` unchanged. While halted, it also wakes the block with `resume_mode`=0.
- R9: When several wake sources are active in one cycle, priority is external reset, then watchdog overflow, then interrupt, then port or remote edge. `chip_reset` and `warm_reset` are never high together.
- R10: `sys_clk_en` returns to 1 in the cycle after the wake. `resume_strobe` is a one-cycle pulse `SETTLE_CYCLES` cycles after the wake edge for `resume_mode`=0, and one cycle later for `resume_mode`=1. `resume_mode` does not change from the wake until the strobe.
- R11: `clrwdt_strobe` in the running state clears `pdf` on the next cycle and leaves `to_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| halt_strobe | input | 1 | Core executed the halt instruction |
| clrwdt_strobe | input | 1 | Core executed the clear-watchdog instruction |
| ext_reset | input | 1 | External reset request (synchronous) |
| port_in | input | PORT_W | Port input levels |
| port_wake_en | input | PORT_W | Per-bit port wake enables |
| rmt_in | input | 1 | Remote-control pin level |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| irq_req | input | IRQ_W | Interrupt request flags |
| irq_en | input | IRQ_W | Interrupt enable flags |
| stack_full | input | 1 | Return stack has no free entry |
| sys_clk_en | output | 1 | System clock enable for the core |
| chip_reset | output | 1 | One-cycle full chip reset |
| warm_reset | output | 1 | One-cycle reset of program counter and stack pointer |
| wdt_restart | output | 1 | One-cycle watchdog clear-and-restart |
| pdf | output | 1 | Power-down status flag |
| to_flag | output | 1 | Time-out status flag |
| resume_mode | output | 1 | 0: next instruction, 1: interrupt vector |
| resume_strobe | output | 1 | One-cycle resume command |

## Verification
The bench targets three groups of corner cases.

The first is interrupt qualification. An enabled request with a full stack must resume at the next instruction, and a request already pending at halt entry must never wake the block. A design that skipped either check would enter the interrupt vector with no stack room, or would fall straight back out of halt.

The second is simultaneous sources. The bench pairs external reset with watchdog overflow, and watchdog overflow with an interrupt. A wrong priority shows up as the wrong reset pulse, a stray `to_flag`, or a vector resume.

The third is edge qualification and settle timing. The bench drives port edges on disabled bits, rising edges, and an edge taken before halting. It also measures the exact distance from wake to strobe for both resume modes, which catches an off-by-one settle counter or a missing extra interrupt cycle.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_VEC    = 2'd3
  } hwc_state_e;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_EXT  = 3'd1,
    WK_WDT  = 3'd2,
    WK_IRQ  = 3'd3,
    WK_EDGE = 3'd4
  } wake_src_e;

  typedef enum logic {
    RES_NEXT   = 1'b0,
    RES_VECTOR = 1'b1
  } resume_e;

endpackage

// File: rtl/hwc_edge_detect.sv
module hwc_edge_detect #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armed,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] port_wake_en,
  input  logic              rmt_in,
  output logic              edge_wake
);

  logic [PORT_W-1:0] port_prev_q;
  logic [PORT_W-1:0] port_fall;
  logic              rmt_prev_q;
  logic              rmt_change;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_prev_q <= port_in;
      rmt_prev_q  <= rmt_in;
    end else begin
      port_prev_q <= port_in;
      rmt_prev_q  <= rmt_in;
    end
  end

  for (genvar b = 0; b < PORT_W; b++) begin : g_bit
    assign port_fall[b] = port_prev_q[b] & ~port_in[b] & port_wake_en[b];
  end

  assign rmt_change = rmt_prev_q ^ rmt_in;
  assign edge_wake  = armed & ((|port_fall) | rmt_change);

endmodule

// File: rtl/hwc_wake_arbiter.sv
module hwc_wake_arbiter
  import hwc_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halted,
  input  logic             ext_reset,
  input  logic             wdt_ovf,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic [IRQ_W-1:0] irq_block,
  input  logic             stack_full,
  input  logic             edge_wake,
  output logic             wake,
  output wake_src_e        src,
  output logic             vec
);

  logic [IRQ_W-1:0] irq_fresh;
  logic             irq_take;

  assign irq_fresh = irq_req & ~irq_block;
  assign irq_take  = |(irq_fresh & irq_en);

  always_comb begin
    src = WK_NONE;
    vec = 1'b0;
    if (halted) begin
      if (ext_reset) begin
        src = WK_EXT;
      end else if (wdt_ovf) begin
        src = WK_WDT;
      end else if (|irq_fresh) begin
        src = WK_IRQ;
        vec = irq_take & ~stack_full;
      end else if (edge_wake) begin
        src = WK_EDGE;
      end
    end
  end

  assign wake = (src != WK_NONE);

  AST_VEC_QUAL: assert property (@(posedge clk) disable iff (rst)
    vec |-> (!stack_full && !ext_reset && !wdt_ovf)) else $error("vector wake not qualified"); // R5

  AST_WAKE_HALTED: assert property (@(posedge clk) disable iff (rst)
    wake |-> halted) else $error("wake outside halt"); // R3

endmodule

// File: rtl/hwc_settle_timer.sv
module hwc_settle_timer #(
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = run_q;
  assign done = run_q & (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST) else $error("settle count overflow"); // R10

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !busy) else $error("settle did not stop"); // R10

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import hwc_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int IRQ_W         = 4,
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_strobe,
  input  logic              clrwdt_strobe,
  input  logic              ext_reset,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] port_wake_en,
  input  logic              rmt_in,
  input  logic              wdt_ovf,
  input  logic [IRQ_W-1:0]  irq_req,
  input  logic [IRQ_W-1:0]  irq_en,
  input  logic              stack_full,
  output logic              sys_clk_en,
  output logic              chip_reset,
  output logic              warm_reset,
  output logic              wdt_restart,
  output logic              pdf,
  output logic              to_flag,
  output logic              resume_mode,
  output logic              resume_strobe
);

  hwc_state_e       st_q;
  logic             clk_en_q;
  logic             pdf_q;
  logic             to_q;
  logic             chip_q;
  logic             warm_q;
  logic             wdtr_q;
  resume_e          mode_q;
  logic             strobe_q;
  logic [IRQ_W-1:0] irq_block_q;

  logic             halted;
  logic             edge_wake;
  logic             wake;
  wake_src_e        wake_src;
  logic             wake_vec;
  logic             tmr_busy;
  logic             tmr_done;

  assign halted = (st_q == ST_HALT);

  hwc_edge_detect #(
    .PORT_W (PORT_W)
  ) u_edge (
    .clk          (clk),
    .rst          (rst),
    .armed        (halted),
    .port_in      (port_in),
    .port_wake_en (port_wake_en),
    .rmt_in       (rmt_in),
    .edge_wake    (edge_wake)
  );

  hwc_wake_arbiter #(
    .IRQ_W (IRQ_W)
  ) u_arb (
    .clk        (clk),
    .rst        (rst),
    .halted     (halted),
    .ext_reset  (ext_reset),
    .wdt_ovf    (wdt_ovf),
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .irq_block  (irq_block_q),
    .stack_full (stack_full),
    .edge_wake  (edge_wake),
    .wake       (wake),
    .src        (wake_src),
    .vec        (wake_vec)
  );

  hwc_settle_timer #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_settle (
    .clk   (clk),
    .rst   (rst),
    .start (wake),
    .busy  (tmr_busy),
    .done  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_RUN;
      clk_en_q    <= 1'b1;
      pdf_q       <= 1'b0;
      to_q        <= 1'b0;
      chip_q      <= 1'b0;
      warm_q      <= 1'b0;
      wdtr_q      <= 1'b0;
      mode_q      <= RES_NEXT;
      strobe_q    <= 1'b0;
      irq_block_q <= '0;
    end else begin
      chip_q   <= 1'b0;
      warm_q   <= 1'b0;
      wdtr_q   <= 1'b0;
      strobe_q <= 1'b0;
      unique case (st_q)
        ST_RUN: begin
          if (ext_reset) begin
            chip_q <= 1'b1;
          end else if (halt_strobe) begin
            st_q        <= ST_HALT;
            clk_en_q    <= 1'b0;
            pdf_q       <= 1'b1;
            to_q        <= 1'b0;
            wdtr_q      <= 1'b1;
            irq_block_q <= irq_req;
          end else if (clrwdt_strobe) begin
            pdf_q <= 1'b0;
          end
        end
        ST_HALT: begin
          if (wake) begin
            st_q     <= ST_SETTLE;
            clk_en_q <= 1'b1;
            mode_q   <= wake_vec ? RES_VECTOR : RES_NEXT;
            if (wake_src == WK_EXT) begin
              chip_q <= 1'b1;
            end else if (wake_src == WK_WDT) begin
              warm_q <= 1'b1;
              to_q   <= 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (ext_reset) chip_q <= 1'b1;
          if (tmr_done) begin
            if (mode_q == RES_VECTOR) begin
              st_q <= ST_VEC;
            end else begin
              st_q     <= ST_RUN;
              strobe_q <= 1'b1;
            end
          end
        end
        ST_VEC: begin
          if (ext_reset) chip_q <= 1'b1;
          st_q     <= ST_RUN;
          strobe_q <= 1'b1;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign sys_clk_en    = clk_en_q;
  assign chip_reset    = chip_q;
  assign warm_reset    = warm_q;
  assign wdt_restart   = wdtr_q;
  assign pdf           = pdf_q;
  assign to_flag       = to_q;
  assign resume_mode   = mode_q;
  assign resume_strobe = strobe_q;

  AST_POR_STATE: assert property (@(posedge clk)
    rst |=> (sys_clk_en && !pdf && !to_flag && !resume_strobe && !chip_reset && !warm_reset))
    else $error("reset state wrong"); // R1

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && halt_strobe && !ext_reset) |=> (!sys_clk_en && pdf && !to_flag && wdt_restart))
    else $error("halt entry wrong"); // R2

  AST_WARM_SETS_TO: assert property (@(posedge clk) disable iff (rst)
    warm_reset |-> (to_flag && pdf)) else $error("warm reset without time-out"); // R7

  AST_RESET_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(chip_reset && warm_reset)) else $error("both resets"); // R9

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    resume_strobe |=> !resume_strobe) else $error("strobe too long"); // R10

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SETTLE || st_q == ST_VEC) |=> $stable(resume_mode)) else $error("mode moved"); // R10

  AST_CLK_DURING_SETTLE: assert property (@(posedge clk) disable iff (rst)
    tmr_busy |-> sys_clk_en) else $error("clock off in settle"); // R10

  AST_CLRWDT_PDF: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && clrwdt_strobe && !halt_strobe && !ext_reset) |=> (!pdf && $stable(to_flag)))
    else $error("clear-watchdog flag handling"); // R11

endmodule

// File: tb/halt_wake_ctrl_test.sv
`timescale 1ns/1ps
module halt_wake_ctrl_test;

  localparam int PORT_W = 8;
  localparam int IRQ_W  = 4;
  localparam int SETTLE = 1024;
  localparam int NV     = 13;

  typedef struct packed {
    logic [7:0] fall;
    logic [7:0] pen;
    logic       rmt;
    logic [3:0] irq;
    logic [3:0] ien;
    logic       stk;
    logic       wdt;
    logic       ext;
    logic       e_wake;
    logic       e_vec;
    logic       e_warm;
    logic       e_chip;
    logic       e_to;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{8'h04, 8'h04, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h20, 8'h01, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h00, 8'h00, 1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h00, 8'h00, 1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h00, 8'h00, 1'b0, 4'h2, 4'h2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h00, 8'h00, 1'b0, 4'h2, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h00, 8'h00, 1'b0, 4'h8, 4'h8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h00, 8'h00, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'h00, 8'h00, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'h00, 8'h00, 1'b0, 4'h1, 4'h1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'h00, 8'h00, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'h01, 8'h01, 1'b0, 4'h1, 4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h80, 8'hFF, 1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              halt_strobe, clrwdt_strobe, ext_reset;
  logic [PORT_W-1:0] port_in, port_wake_en;
  logic              rmt_in, wdt_ovf;
  logic [IRQ_W-1:0]  irq_req, irq_en;
  logic              stack_full;
  logic              sys_clk_en, chip_reset, warm_reset, wdt_restart;
  logic              pdf, to_flag, resume_mode, resume_strobe;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  halt_wake_ctrl #(.PORT_W(PORT_W), .IRQ_W(IRQ_W), .SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst(rst), .halt_strobe(halt_strobe), .clrwdt_strobe(clrwdt_strobe),
    .ext_reset(ext_reset), .port_in(port_in), .port_wake_en(port_wake_en),
    .rmt_in(rmt_in), .wdt_ovf(wdt_ovf), .irq_req(irq_req), .irq_en(irq_en),
    .stack_full(stack_full), .sys_clk_en(sys_clk_en), .chip_reset(chip_reset),
    .warm_reset(warm_reset), .wdt_restart(wdt_restart), .pdf(pdf), .to_flag(to_flag),
    .resume_mode(resume_mode), .resume_strobe(resume_strobe));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tag(input int i);
    case (i)
      0, 1:    return "R3";
      2, 3, 12: return "R4";
      4, 5, 6: return "R5";
      7:       return "R7";
      8:       return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic enter_halt(input string req);
    @(negedge clk) halt_strobe = 1'b1;
    @(negedge clk) halt_strobe = 1'b0;
    chk(req, "clk_en after halt", sys_clk_en, 0);
    chk(req, "pdf after halt", pdf, 1);
    chk(req, "to after halt", to_flag, 0);
    chk(req, "wdt_restart", wdt_restart, 1);
  endtask

  // counts posedges from the wake edge (already taken = 1) to the strobe
  task automatic wait_strobe(input logic exp_mode, input string req);
    int n = 1;
    bit moved = 0;
    while (!resume_strobe && n < SETTLE + 20) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (resume_mode !== exp_mode) moved = 1;
    end
    chk("R10", {req, " strobe latency"}, n, SETTLE + 1 + int'(exp_mode));
    chk("R10", {req, " mode held"}, moved, 0);
    @(negedge clk);
    chk("R10", {req, " strobe single"}, resume_strobe, 0);
  endtask

  task automatic idle_inputs();
    port_in = '1; irq_req = '0; irq_en = '0; stack_full = 1'b0;
    wdt_ovf = 1'b0; ext_reset = 1'b0; halt_strobe = 1'b0; clrwdt_strobe = 1'b0;
  endtask

  task automatic wdt_kick();
    @(negedge clk) wdt_ovf = 1'b1;
    @(negedge clk) wdt_ovf = 1'b0;
    wait_strobe(1'b0, "recover");
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rmt_in = 1'b0; port_wake_en = '0;
    idle_inputs();
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "clk_en in reset", sys_clk_en, 1);
    chk("R1", "pdf in reset", pdf, 0);
    chk("R1", "to in reset", to_flag, 0);
    chk("R1", "pulses in reset", {chip_reset, warm_reset, resume_strobe}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      enter_halt("R2");
      port_wake_en = VT[i].pen;
      port_in      = ~VT[i].fall;
      rmt_in       = rmt_in ^ VT[i].rmt;
      irq_req      = VT[i].irq;
      irq_en       = VT[i].ien;
      stack_full   = VT[i].stk;
      wdt_ovf      = VT[i].wdt;
      ext_reset    = VT[i].ext;
      @(negedge clk);
      wdt_ovf = 1'b0; ext_reset = 1'b0;
      chk(tag(i), $sformatf("v%0d clk_en", i), sys_clk_en, VT[i].e_wake);
      chk(tag(i), $sformatf("v%0d warm", i), warm_reset, VT[i].e_warm);
      chk(tag(i), $sformatf("v%0d chip", i), chip_reset, VT[i].e_chip);
      chk(tag(i), $sformatf("v%0d to", i), to_flag, VT[i].e_to);
      chk(tag(i), $sformatf("v%0d pdf", i), pdf, 1);
      if (VT[i].e_wake) begin
        chk(tag(i), $sformatf("v%0d mode", i), resume_mode, VT[i].e_vec);
        wait_strobe(VT[i].e_vec, tag(i));
      end else begin
        repeat (5) @(negedge clk);
        chk(tag(i), $sformatf("v%0d stays halted", i), sys_clk_en, 0);
        wdt_kick();
      end
      idle_inputs();
      @(negedge clk);
    end

    // R6: request pending at halt entry does not wake
    irq_req = 4'h1; irq_en = 4'hF;
    enter_halt("R6");
    repeat (8) @(negedge clk);
    chk("R6", "pending irq no wake", sys_clk_en, 0);
    irq_req = 4'h5;
    @(negedge clk);
    chk("R6", "fresh irq wakes", sys_clk_en, 1);
    chk("R5", "fresh irq vector", resume_mode, 1);
    wait_strobe(1'b1, "R5");
    idle_inputs();

    // R3: edge while running ignored, rising edge in halt ignored
    port_wake_en = 8'h01;
    @(negedge clk) port_in = 8'hFE;
    enter_halt("R3");
    repeat (4) @(negedge clk);
    chk("R3", "run-time edge no wake", sys_clk_en, 0);
    port_in = 8'hFF;
    repeat (4) @(negedge clk);
    chk("R3", "rising edge no wake", sys_clk_en, 0);
    port_in = 8'hFE;
    @(negedge clk);
    chk("R3", "halt fall wakes", sys_clk_en, 1);
    wait_strobe(1'b0, "R3");
    idle_inputs();

    // R11: clear-watchdog clears pdf, keeps to
    enter_halt("R2");
    @(negedge clk) wdt_ovf = 1'b1;
    @(negedge clk) wdt_ovf = 1'b0;
    wait_strobe(1'b0, "R7");
    chk("R7", "to set after wdt wake", to_flag, 1);
    @(negedge clk) clrwdt_strobe = 1'b1;
    @(negedge clk) clrwdt_strobe = 1'b0;
    chk("R11", "pdf cleared", pdf, 0);
    chk("R11", "to kept", to_flag, 1);

    // R8: external reset while running
    @(negedge clk) ext_reset = 1'b1;
    @(negedge clk) ext_reset = 1'b0;
    chk("R8", "chip pulse in run", chip_reset, 1);
    chk("R8", "flags kept", {pdf, to_flag}, 2'b01);
    chk("R8", "clock stays", sys_clk_en, 1);
    @(negedge clk);
    chk("R8", "chip single", chip_reset, 0);

    // R1: reset while halted
    enter_halt("R2");
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk("R1", "reset in halt clk_en", sys_clk_en, 1);
    chk("R1", "reset in halt pdf", pdf, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule